// File: doc/BRIEF.md
# Packed Pixel Unpacking Multiplexer

This block sits between a pixel-data FIFO and the next stage of a video pipeline. It takes 64-bit beats, each made of two 32-bit words, and cuts them into pixels of a selectable depth. It emits one pixel per transfer on a 24-bit output word. Pixels narrower than 24 bits are zero-extended. In 24-bit mode a pixel may span two beats. Leftover bits are held in an internal accumulator and joined with the next beat in order, so every three beats give eight pixels.

Both sides use valid/ready handshakes. A 3-bit mode code selects the depth. The code is sampled only on a frame-start pulse and applied once the output register is empty. Applying it clears any bits still held. Mode 3'b000 turns the block off. A code outside the legal set also turns it off and raises an error flag.

Top module: `pix_unpack_top`

## Requirements
- R1: After synchronous reset, pix_valid, beat_ready and mode_err are low and the active mode is off (3'b000).
- R2: While the active mode is 3'b000, beat_ready stays low, no pixel is emitted and mode_err is low.
- R3: Mode codes map to depths as 3'b001 = 4, 3'b010 = 8, 3'b100 = 16, 3'b101 = 24 bits. Pixel k of a mode's bit stream is bits [k*d +: d]. The stream is formed by appending each accepted beat above the bits already held, with beat bit 0 first. So the lower 32-bit word is consumed before the upper one.
- R4: pix_data carries the pixel in its low d bits, and bits 23:d are zero.
- R5: In 24-bit mode, pixels that straddle beats are joined in order, and three beats yield exactly eight pixels.
- R6: Applying any code other than 000, 001, 010, 100, 101 makes the block behave as in R2 and sets mode_err high. mode_err stays high until a legal code is applied, which clears it.
- R7: mode_in is sampled only in the cycle frame_start is high, and changing it at other times has no effect. The sampled code becomes active after the output register has drained. Applying it discards every held bit, so the first pixel of the new mode starts at bit 0 of the next accepted beat.
- R8: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data holds its value. No pixel is lost or repeated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse that samples mode_in |
| mode_in | input | 3 | Requested depth code |
| beat_valid | input | 1 | Input beat is valid |
| beat_data | input | 64 | Input beat, two 32-bit words, lower word in bits 31:0 |
| beat_ready | output | 1 | Block accepts the beat this cycle |
| pix_valid | output | 1 | Output pixel is valid |
| pix_data | output | 24 | Output pixel, zero-extended |
| pix_ready | input | 1 | Downstream accepts the pixel |
| mode_err | output | 1 | Active mode code is illegal |

## Verification
The bench builds the block with its default parameters: 64-bit beats, a 24-bit pixel word and an 88-bit accumulator. At these values every legal depth can be reached, including the 24-bit case where the held bit count cycles through 0, 16 and 8 across beats. The scoreboard models the bit stream on its own and compares each pixel with the model. Pseudo-random back-pressure on pix_ready hits stalls at every residue state. Mode changes are exercised with a partial pixel still held, with mode_in changed and no pulse, and with two illegal codes.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int MODE_W  = 3;
  localparam int DEPTH_W = 5;

  localparam logic [MODE_W-1:0] PM_OFF = 3'b000;
  localparam logic [MODE_W-1:0] PM_D4  = 3'b001;
  localparam logic [MODE_W-1:0] PM_D8  = 3'b010;
  localparam logic [MODE_W-1:0] PM_D16 = 3'b100;
  localparam logic [MODE_W-1:0] PM_D24 = 3'b101;

  // Pixel depth in bits for a mode code, zero when no pixels are produced
  function automatic logic [DEPTH_W-1:0] depth_of(input logic [MODE_W-1:0] m);
    case (m)
      PM_D4:   return DEPTH_W'(4);
      PM_D8:   return DEPTH_W'(8);
      PM_D16:  return DEPTH_W'(16);
      PM_D24:  return DEPTH_W'(24);
      default: return '0;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == PM_OFF) || (depth_of(m) != '0);
  endfunction
endpackage

// File: rtl/pix_mode_ctrl.sv
module pix_mode_ctrl
  import pix_unpack_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [MODE_W-1:0]  mode_in,
  input  logic               out_empty,
  output logic               pending,
  output logic               flush,
  output logic [MODE_W-1:0]  act_mode,
  output logic [DEPTH_W-1:0] depth,
  output logic               mode_err
);
  logic              pend_r;
  logic [MODE_W-1:0] pend_mode_r;
  logic [MODE_W-1:0] act_r;
  logic              err_r;

  // apply a sampled code only once the output register holds nothing
  assign flush = pend_r && out_empty && !frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_r      <= 1'b0;
      pend_mode_r <= PM_OFF;
      act_r       <= PM_OFF;
      err_r       <= 1'b0;
    end else if (frame_start) begin
      pend_r      <= 1'b1;
      pend_mode_r <= mode_in;
    end else if (flush) begin
      pend_r <= 1'b0;
      act_r  <= pend_mode_r;
      err_r  <= !mode_legal(pend_mode_r);
    end
  end

  assign pending  = pend_r;
  assign act_mode = act_r;
  assign depth    = depth_of(act_r);
  assign mode_err = err_r;
endmodule

// File: rtl/pix_bit_accum.sv
module pix_bit_accum #(
  parameter int BEAT_W  = 64,
  parameter int PIX_W   = 24,
  parameter int DEPTH_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               hold,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               beat_valid,
  input  logic [BEAT_W-1:0]  beat_data,
  output logic               beat_ready,
  output logic               emit_valid,
  output logic [PIX_W-1:0]   emit_data,
  input  logic               emit_ready
);
  localparam int BUF_W = BEAT_W + PIX_W;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] acc_r;
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] depth_ext;
  logic [PIX_W-1:0] pix_mask;
  logic             live;

  assign depth_ext  = CNT_W'(depth);
  assign live       = !hold && (depth != '0);
  // a beat is taken only when fewer than one pixel of bits remain,
  // so the held count never exceeds BEAT_W + depth - 1
  assign beat_ready = live && (cnt_r < depth_ext);
  assign emit_valid = live && (cnt_r >= depth_ext);
  assign pix_mask   = (PIX_W'(1) << depth) - PIX_W'(1);
  assign emit_data  = acc_r[PIX_W-1:0] & pix_mask;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc_r <= '0;
      cnt_r <= '0;
    end else if (beat_valid && beat_ready) begin
      acc_r <= acc_r | ({{PIX_W{1'b0}}, beat_data} << cnt_r);
      cnt_r <= cnt_r + CNT_W'(BEAT_W);
    end else if (emit_valid && emit_ready) begin
      acc_r <= acc_r >> depth;
      cnt_r <= cnt_r - depth_ext;
    end
  end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  output logic             in_ready,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  input  logic             pix_ready
);
  logic             v_r;
  logic [PIX_W-1:0] d_r;

  assign in_ready = !v_r || pix_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_r <= 1'b0;
      d_r <= '0;
    end else if (in_ready) begin
      v_r <= in_valid;
      if (in_valid) d_r <= in_data;
    end
  end

  assign pix_valid = v_r;
  assign pix_data  = d_r;
endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
  import pix_unpack_pkg::*;
#(
  parameter int BEAT_W = 64,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [2:0]        mode_in,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              beat_ready,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  input  logic              pix_ready,
  output logic              mode_err
);
  logic               pending;
  logic               flush;
  logic [MODE_W-1:0]  act_mode;
  logic [DEPTH_W-1:0] depth;
  logic               emit_valid;
  logic [PIX_W-1:0]   emit_data;
  logic               emit_ready;

  pix_mode_ctrl u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .mode_in(mode_in),
    .out_empty(!pix_valid), .pending(pending), .flush(flush),
    .act_mode(act_mode), .depth(depth), .mode_err(mode_err)
  );

  pix_bit_accum #(.BEAT_W(BEAT_W), .PIX_W(PIX_W), .DEPTH_W(DEPTH_W)) u_accum (
    .clk(clk), .rst(rst), .flush(flush), .hold(pending), .depth(depth),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
    .emit_valid(emit_valid), .emit_data(emit_data), .emit_ready(emit_ready)
  );

  pix_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(emit_valid), .in_data(emit_data),
    .in_ready(emit_ready), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
  import pix_unpack_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_ready,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             pix_ready,
  input logic             mode_err,
  input logic [2:0]       act_mode
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data)) else $error("stall"); // R8

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    act_mode == PM_OFF |-> !beat_ready && !pix_valid && !mode_err) else $error("off"); // R2

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !beat_ready && !pix_valid) else $error("err"); // R6

  AST_ERR_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !mode_legal(act_mode)) else $error("err code"); // R6

  AST_D8_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    pix_valid && act_mode == PM_D8 |-> pix_data[PIX_W-1:8] == '0) else $error("ext8"); // R4

  AST_D16_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    pix_valid && act_mode == PM_D16 |-> pix_data[PIX_W-1:16] == '0) else $error("ext16"); // R4
endmodule

bind pix_unpack_top pix_unpack_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .beat_ready(beat_ready), .pix_valid(pix_valid),
  .pix_data(pix_data), .pix_ready(pix_ready), .mode_err(mode_err),
  .act_mode(act_mode)
);

// File: tb/tb_pix_unpack_top.sv
module tb_pix_unpack_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [2:0]  mode_in = 3'b000;
  logic        beat_valid = 1'b0;
  logic [63:0] beat_data = '0;
  logic        beat_ready;
  logic        pix_valid;
  logic [23:0] pix_data;
  logic        pix_ready = 1'b1;
  logic        mode_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] exp_q[$];
  logic [127:0] sb_bits;
  int sb_n = 0;
  int cur_dep = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'hA5;
  bit held = 0;
  logic [23:0] held_data;
  int cyc = 0;

  always #4 clk = ~clk;

  pix_unpack_top dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .mode_in(mode_in),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // R3 encodings: 001=4, 010=8, 100=16, 101=24, else none
  function automatic int dep_of(input logic [2:0] m);
    case (m)
      3'b001: return 4;
      3'b010: return 8;
      3'b100: return 16;
      3'b101: return 24;
      default: return 0;
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // back-pressure pattern
  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1 pix_ready = stall_en ? lfsr[0] | lfsr[2] : 1'b1;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (held && pix_valid) chk(pix_data == held_data, "R8 stall hold", pix_data, held_data);
      held = 0;
      if (pix_valid && pix_ready) begin
        if (exp_q.size() == 0) chk(0, "R8 extra pixel", pix_data, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(pix_data == e, "R3 R4 R5 pixel", pix_data, e);
        end
      end else if (pix_valid) begin
        held = 1;
        held_data = pix_data;
      end
    end
  end

  task automatic set_mode(input logic [2:0] m);
    @(posedge clk); #1;
    frame_start = 1'b1; mode_in = m;
    @(posedge clk); #1;
    frame_start = 1'b0;
    sb_bits = '0; sb_n = 0; cur_dep = dep_of(m);
    repeat (3) @(posedge clk);
  endtask

  task automatic send_beat(input logic [63:0] b);
    bit acc;
    sb_bits[sb_n +: 64] = b;
    sb_n += 64;
    while (cur_dep != 0 && sb_n >= cur_dep) begin
      exp_q.push_back(sb_bits[23:0] & ((24'h1 << cur_dep) - 24'h1));
      sb_bits = sb_bits >> cur_dep;
      sb_n -= cur_dep;
    end
    @(posedge clk); #1;
    beat_valid = 1'b1; beat_data = b;
    do begin
      @(negedge clk); acc = beat_ready;
      @(posedge clk);
    end while (!acc);
    #1 beat_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(posedge clk); t++; end
    chk(exp_q.size() == 0, "R8 missing pixels", exp_q.size(), 0);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!pix_valid, "R1 pix_valid", pix_valid, 0);
    chk(!beat_ready, "R1 beat_ready", beat_ready, 0);
    chk(!mode_err, "R1 mode_err", mode_err, 0);

    // R2: off mode takes nothing
    beat_valid = 1'b1; beat_data = 64'hDEAD_BEEF_0000_1111;
    repeat (4) begin
      @(negedge clk);
      chk(!beat_ready && !pix_valid && !mode_err, "R2 off", {beat_ready, pix_valid, mode_err}, 0);
    end
    @(posedge clk); #1 beat_valid = 1'b0;

    // R3 8-bit, lower word first
    set_mode(3'b010);
    send_beat(64'h8877_6655_4433_2211);
    send_beat(64'h0123_4567_89AB_CDEF);
    drain();

    // R3 R8 4-bit with stalls
    stall_en = 1;
    set_mode(3'b001);
    send_beat(64'hFEDC_BA98_7654_3210);
    send_beat(64'h0F1E_2D3C_4B5A_6978);
    drain();

    // R4 16-bit
    set_mode(3'b100);
    for (int i = 0; i < 3; i++) send_beat(64'hA5A5_0000_FFFF_1234 ^ (64'(i) << 17));
    drain();

    // R5 24-bit straddle, stalls active
    set_mode(3'b101);
    for (int i = 0; i < 6; i++) send_beat({32'hC0DE_0000 + 32'(i), 32'h1357_9BDF ^ 32'(i * 77)});
    drain();

    // R7 mode_in change without pulse has no effect
    @(posedge clk); #1 mode_in = 3'b001;
    for (int i = 0; i < 3; i++) send_beat(64'h1111_2222_3333_4444 * 64'(i + 3));
    drain();

    // R7 held residue discarded on mode change
    send_beat(64'hAAAA_BBBB_CCCC_DDDD);
    drain();
    set_mode(3'b010);
    send_beat(64'h0807_0605_0403_0201);
    drain();

    // R6 illegal codes
    stall_en = 0;
    set_mode(3'b111);
    beat_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(mode_err && !beat_ready && !pix_valid, "R6 illegal 111", {mode_err, beat_ready, pix_valid}, 3'b100);
    end
    beat_valid = 1'b0;
    set_mode(3'b011);
    @(negedge clk);
    chk(mode_err && !beat_ready, "R6 illegal 011", {mode_err, beat_ready}, 2'b10);
    set_mode(3'b100);
    @(negedge clk);
    chk(!mode_err, "R6 cleared", mode_err, 0);
    send_beat(64'h0000_9999_8888_7777);
    drain();

    summary();
  end
endmodule